// File: doc/BRIEF.md
# Byte-Lane Write Strobe Decoder

This block sits between a processor bus and a set of byte-wide memory banks. The bus carries one active-low enable per byte lane, a memory/IO qualifier and a write/read qualifier. The block turns these into one active-low write strobe per bank.

Each strobe fires only when three things hold: its own lane enable is low, the cycle is a memory write, and the address falls inside a fixed window. The same window match, qualified by a memory cycle, also gives an active-low region enable for the bank chip-enables.

The lane count is a parameter: 2 for a 16-bit bus, 4 for a 32-bit bus, 8 for a 64-bit bus. The address bits that select a byte inside a bus word never reach the memory. The block passes on the word address with those bits dropped. Read cycles use no strobes, because the processor picks the bytes it needs from the full bus word. On a 2-lane bus the low-lane enable input is wired to bus address bit 0.

The block is purely combinational. It has no clock and no reset.

Top module: `byte_strobe_dec`

## Requirements
- R1: `mem_wr_n` is low exactly when `mem_io` is 1 (memory cycle) and `wr_rd` is 1 (write).
- R2: `region_en_n` is low exactly when `mem_io` is 1 and address bits 23..20 equal the window base. The window base defaults to 0, so by default the window is 0x000000 to 0x0FFFFF.
- R3: `lane_wr_n[i]` is low exactly when `lane_en_n[i]` is 0, the cycle is a memory write, and the address is inside the window.
- R4: each lane strobe depends only on its own enable. Changing another lane's enable leaves it unchanged.
- R5: when `wr_rd` is 0 (read), every lane strobe is high, whatever the enables are.
- R6: when `mem_io` is 0 (IO cycle), every lane strobe and `region_en_n` are high.
- R7: address bits below bit 20 have no effect on `region_en_n` or on any lane strobe. This includes the byte-select bits (bit 0 on 2 lanes, bits 1..0 on 4 lanes, bits 2..0 on 8 lanes).
- R8: `word_addr` equals `addr` shifted right by log2(LANES). Bus bit A1 (2 lanes) or A3 (8 lanes) becomes word bit 0.
- R9: on a 2-lane bus the four enable codes behave as follows, written as {high enable, low enable}:
  - 00 writes both banks.
  - 01 writes the high bank only.
  - 10 writes the low bank only.
  - 11 writes neither bank.
- R10: all enables high during an in-window memory write leaves every strobe high, while `mem_wr_n` and `region_en_n` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_en_n | input | LANES | Active-low byte lane enables; bit i is lane i |
| mem_io | input | 1 | 1 = memory cycle, 0 = IO cycle |
| wr_rd | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address on the bus |
| lane_wr_n | output | LANES | Active-low write strobe per bank |
| mem_wr_n | output | 1 | Active-low memory-write qualifier |
| region_en_n | output | 1 | Active-low enable for the address window |
| word_addr | output | ADDR_W-log2(LANES) | Word address presented to the banks |

## Verification
The bench builds two copies of the block.

The 8-lane default copy has every one of the 256 enable patterns crossed with both qualifiers and with window nibbles inside, beside and far from the base. This exposes any lane that listens to a neighbour's enable or ignores the window.

The 2-lane copy is swept exhaustively over both enables, both qualifiers and all sixteen window nibbles. This covers the 16-bit bank selection codes and the shift of the word address by one bit instead of three.

Low address bits vary on every vector, so a decode that wrongly looks below the window shows up.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  // log2 of the supported lane counts; anything else falls back to 1
  function automatic int lane_shift(input int lanes);
    if (lanes == 8) return 3;
    else if (lanes == 4) return 2;
    else return 1;
  endfunction

endpackage

// File: rtl/bwd_wrqual.sv
module bwd_wrqual (
  input  logic mem_io,
  input  logic wr_rd,
  output logic mem_wr_n
);

  always_comb begin
    mem_wr_n = ~(mem_io & wr_rd);
  end

endmodule

// File: rtl/bwd_window.sv
module bwd_window #(
  parameter int                ADDR_W   = 24,
  parameter int                WIN_LO   = 20,
  parameter int                WIN_W    = 4,
  parameter logic [WIN_W-1:0]  WIN_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_io,
  output logic              win_hit,
  output logic              region_en_n
);

  localparam int WIN_HI = WIN_LO + WIN_W - 1;

  always_comb begin
    win_hit     = (addr[WIN_HI:WIN_LO] == WIN_BASE);
    region_en_n = ~(win_hit & mem_io);
  end

endmodule

// File: rtl/bwd_lane_gate.sv
module bwd_lane_gate (
  input  logic en_n,
  input  logic mem_wr_n,
  input  logic win_hit,
  output logic wr_n
);

  // active-low AND: strobe only when every term is active
  always_comb begin
    wr_n = en_n | mem_wr_n | ~win_hit;
  end

endmodule

// File: rtl/byte_strobe_dec.sv
module byte_strobe_dec
  import bwd_pkg::*;
#(
  parameter int                LANES    = 8,
  parameter int                ADDR_W   = 24,
  parameter int                WIN_LO   = 20,
  parameter int                WIN_W    = 4,
  parameter logic [WIN_W-1:0]  WIN_BASE = '0,
  localparam int               LSB      = lane_shift(LANES),
  localparam int               WA_W     = ADDR_W - LSB
) (
  input  logic [LANES-1:0]  lane_en_n,
  input  logic              mem_io,
  input  logic              wr_rd,
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  lane_wr_n,
  output logic              mem_wr_n,
  output logic              region_en_n,
  output logic [WA_W-1:0]   word_addr
);

  logic win_hit;

  bwd_wrqual u_wrqual (
    .mem_io   (mem_io),
    .wr_rd    (wr_rd),
    .mem_wr_n (mem_wr_n)
  );

  bwd_window #(
    .ADDR_W   (ADDR_W),
    .WIN_LO   (WIN_LO),
    .WIN_W    (WIN_W),
    .WIN_BASE (WIN_BASE)
  ) u_window (
    .addr        (addr),
    .mem_io      (mem_io),
    .win_hit     (win_hit),
    .region_en_n (region_en_n)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bwd_lane_gate u_gate (
      .en_n     (lane_en_n[i]),
      .mem_wr_n (mem_wr_n),
      .win_hit  (win_hit),
      .wr_n     (lane_wr_n[i])
    );
  end

  // byte-select bits stay on the bus side; banks see word address only
  always_comb begin
    word_addr = addr[ADDR_W-1:LSB];
  end

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int LANES  = 8,
  parameter int ADDR_W = 24,
  parameter int WA_W   = 21
) (
  input logic [LANES-1:0]  lane_en_n,
  input logic              mem_io,
  input logic              wr_rd,
  input logic [ADDR_W-1:0] addr,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              mem_wr_n,
  input logic              region_en_n,
  input logic [WA_W-1:0]   word_addr
);

  always_comb begin
    // R3: any active strobe needs the write qualifier and the window enable
    p_strobe_needs_qual_r3: assert (&lane_wr_n || (!mem_wr_n && !region_en_n))
      else $error("lane strobe active without write qualifier or window");
    // R4: a strobe never fires for a lane whose own enable is high
    p_lane_own_enable_r4: assert ((~lane_wr_n & lane_en_n) == '0)
      else $error("lane strobe active with its enable high");
    // R5: read cycles leave every strobe idle
    p_read_idle_r5: assert (wr_rd || &lane_wr_n)
      else $error("lane strobe active on a read");
    // R6: IO cycles drive neither strobes nor the region enable
    p_io_idle_r6: assert (mem_io || (&lane_wr_n && region_en_n))
      else $error("memory output active on an IO cycle");
    // R1: the write qualifier implies a memory cycle
    p_qual_mem_r1: assert (mem_wr_n || mem_io)
      else $error("write qualifier active on an IO cycle");
    // R2: the region enable implies a memory cycle
    p_region_mem_r2: assert (region_en_n || mem_io)
      else $error("region enable active on an IO cycle");
  end

  logic unused_ok;
  always_comb unused_ok = ^{addr, word_addr};

endmodule

bind byte_strobe_dec bwd_checker #(
  .LANES  (LANES),
  .ADDR_W (ADDR_W),
  .WA_W   (WA_W)
) u_chk (
  .lane_en_n   (lane_en_n),
  .mem_io      (mem_io),
  .wr_rd       (wr_rd),
  .addr        (addr),
  .lane_wr_n   (lane_wr_n),
  .mem_wr_n    (mem_wr_n),
  .region_en_n (region_en_n),
  .word_addr   (word_addr)
);

// File: tb/byte_strobe_dec_tb.sv
module byte_strobe_dec_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // 8-lane copy
  logic [7:0]  en8;
  logic        mio8, wr8;
  logic [23:0] a8;
  logic [7:0]  st8;
  logic        mw8, rg8;
  logic [20:0] wa8;

  // 2-lane copy
  logic [1:0]  en2;
  logic        mio2, wr2;
  logic [23:0] a2;
  logic [1:0]  st2;
  logic        mw2, rg2;
  logic [22:0] wa2;

  byte_strobe_dec u_dut (
    .lane_en_n(en8), .mem_io(mio8), .wr_rd(wr8), .addr(a8),
    .lane_wr_n(st8), .mem_wr_n(mw8), .region_en_n(rg8), .word_addr(wa8)
  );

  byte_strobe_dec #(.LANES(2)) u_dut16 (
    .lane_en_n(en2), .mem_io(mio2), .wr_rd(wr2), .addr(a2),
    .lane_wr_n(st2), .mem_wr_n(mw2), .region_en_n(rg2), .word_addr(wa2)
  );

  // {en, mem_io, wr_rd, nibble, exp strobes, exp region_n, exp mem_wr_n}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 1'b1, 1'b1, 4'h0, 8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b1, 4'h0, 8'hFF, 1'b0, 1'b0},
    {8'hA5, 1'b1, 1'b1, 4'h0, 8'hA5, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0, 4'h0, 8'hFF, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b1, 4'h0, 8'hFF, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b1, 4'h1, 8'hFF, 1'b1, 1'b0},
    {8'h7E, 1'b1, 1'b1, 4'h0, 8'h7E, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0, 4'h8, 8'hFF, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive8(input logic [7:0] en, input logic m, input logic w, input logic [23:0] a);
    @(negedge clk);
    en8 = en; mio8 = m; wr8 = w; a8 = a;
    #1;
  endtask

  task automatic drive2(input logic [1:0] en, input logic m, input logic w, input logic [23:0] a);
    @(negedge clk);
    en2 = en; mio2 = m; wr2 = w; a2 = a;
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    en8 = '1; mio8 = 1'b0; wr8 = 1'b0; a8 = '0;
    en2 = '1; mio2 = 1'b0; wr2 = 1'b0; a2 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state: nothing active
    @(negedge clk); #1;
    check("R6 idle strobes", {24'd0, st8}, 32'hFF);
    check("R6 idle region", {31'd0, rg8}, 32'd1);
    check("R1 idle qualifier", {31'd0, mw8}, 32'd1);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      drive8(VEC[v][23:16], VEC[v][15], VEC[v][14],
             {VEC[v][13:10], 20'h5A3C7 ^ 20'(v * 20'h1111)});
      check("R3 table strobes", {24'd0, st8}, {24'd0, VEC[v][9:2]});
      check("R2 table region", {31'd0, rg8}, {31'd0, VEC[v][1]});
      check("R1 table qualifier", {31'd0, mw8}, {31'd0, VEC[v][0]});
    end

    // R4: walking single enable, only that lane fires
    for (int i = 0; i < 8; i++) begin
      drive8(~(8'd1 << i), 1'b1, 1'b1, 24'h012345);
      check("R4 walking lane", {24'd0, st8}, {24'd0, ~(8'd1 << i)});
    end

    // R10: no lane enabled, in-window memory write
    drive8(8'hFF, 1'b1, 1'b1, 24'h0FFFFF);
    check("R10 no lanes strobes", {24'd0, st8}, 32'hFF);
    check("R10 no lanes qualifier", {31'd0, mw8}, 32'd0);
    check("R10 no lanes region", {31'd0, rg8}, 32'd0);

    // 8-lane sweep: R3 R5 R6 R7 R8
    for (int e = 0; e < 256; e++) begin
      for (int q = 0; q < 4; q++) begin
        for (int k = 0; k < 4; k++) begin
          logic [3:0]  nib;
          logic [23:0] a;
          logic        hit, m, w;
          nib = (k == 0) ? 4'h0 : (k == 1) ? 4'h1 : (k == 2) ? 4'h8 : 4'hF;
          m = q[1]; w = q[0];
          a = {nib, 20'((e * 20'h3F1D) ^ (q * 20'h1B7) ^ k)};
          hit = (nib == 4'h0);
          drive8(8'(e), m, w, a);
          check("R3 sweep strobes", {24'd0, st8},
                {24'd0, (hit && m && w) ? 8'(e) : 8'hFF});
          check("R2 R7 sweep region", {31'd0, rg8}, {31'd0, ~(hit && m)});
          check("R8 sweep word address", {11'd0, wa8}, {11'd0, a[23:3]});
        end
      end
    end

    // 2-lane exhaustive: R9 R2 R8
    for (int e = 0; e < 4; e++) begin
      for (int q = 0; q < 4; q++) begin
        for (int n = 0; n < 16; n++) begin
          logic [23:0] a;
          logic        hit, m, w;
          m = q[1]; w = q[0];
          a = {4'(n), 20'((n * 20'h2469B) ^ (e * 20'h777) ^ q)};
          hit = (n == 0);
          drive2(2'(e), m, w, a);
          check("R9 16-bit bank strobes", {30'd0, st2},
                {30'd0, (hit && m && w) ? 2'(e) : 2'b11});
          check("R2 16-bit region", {31'd0, rg2}, {31'd0, ~(hit && m)});
          check("R1 16-bit qualifier", {31'd0, mw2}, {31'd0, ~(m && w)});
          check("R8 16-bit word address", {9'd0, wa2}, {9'd0, a[23:1]});
        end
      end
    end

    // R7: byte-select bits toggled, outputs unchanged
    drive8(8'h3C, 1'b1, 1'b1, 24'h000000);
    check("R7 byte bits zero", {24'd0, st8}, 32'h3C);
    drive8(8'h3C, 1'b1, 1'b1, 24'h0FFFFF);
    check("R7 byte bits ones", {24'd0, st8}, 32'h3C);
    // R5: read with every lane enabled
    drive8(8'h00, 1'b1, 1'b0, 24'h000010);
    check("R5 read no strobes", {24'd0, st8}, 32'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule